// File: doc/BRIEF.md
# DSSS Transmit Preamble Framer with Scrambler

This block produces the serial transmit bit stream of a direct-sequence spread-spectrum baseband, ahead of spreading and modulation. A start request in the idle state captures the preamble mode, the scrambler seed and the header field values. The block then emits, one bit per bit-clock enable, a synchronization field, a 16-bit start-frame delimiter, a 48-bit header and finally the payload.

Payload bits are pulled one at a time from an upstream serial source through a ready/valid handshake, with no frame buffering. Every outgoing bit passes through a self-synchronizing division scrambler (1 + z^-4 + z^-7). After the last payload bit the block returns to idle by itself.

Top module: `dsss_tx_framer`

## Requirements
- R1: A synchronous active-low reset puts the block in idle. While rst_n is low and in the cycle after it, tx_bit=0, tx_bit_vld=0 and busy=0, and tx_rdy stays 0 while idle.
- R2: In idle, start=1 at a rising edge captures short_mode, seed, sig_fld, svc_fld and len_fld, and busy is 1 from the next cycle. A start while busy is ignored and the frame in flight is unchanged.
- R3: With short_mode=0 the stream begins with 128 sync bits that are 1 before scrambling. The delimiter 16'hF3A0 follows at once, bit 0 first.
- R4: With short_mode=1 the stream begins with 56 sync bits that are 0 before scrambling. The delimiter 16'h05CF follows, bit 0 first, and the scrambler is preset to the fixed value SHORT_SEED (default 7'h1B) instead of the seed input.
- R5: After the delimiter come 48 header bits in this order, each field bit 0 first: sig_fld (8 bits), svc_fld (8), len_fld (16), then the 16-bit check word.
- R6: The check word is a CRC over the 32 bits sig_fld, svc_fld, len_fld, taken in transmit order. It uses polynomial x^16+x^12+x^5+1, a register preset to all ones, and inverts the final result.
- R7: Each emitted bit is y = x ^ s[3] ^ s[6], where x is the unscrambled bit and s[6:0] is the scrambler register. s[0] holds the most recent output, and y is shifted into s[0] after each bit. At start, s is loaded with seed (seed[i] to s[i]) in long mode.
- R8: The payload carries len_fld*8 bits. tx_rdy is 1 exactly in cycles where bit_en=1 and the block is in the payload phase. A bit is taken from pl_data when tx_rdy and pl_valid are both 1. After the last payload bit, busy falls and the block is idle.
- R9: A slot with tx_rdy=1 and pl_valid=0 emits no bit: tx_bit_vld=0 for that slot, and the scrambler and bit count do not advance.
- R10: tx_bit and tx_bit_vld are registered and change only at edges where bit_en=1. They take the result of that slot on the following cycle and hold it until the next enabled edge.
- R11: With len_fld=0 the frame ends right after the last check-word bit, with no payload phase.
- R12: Changes on short_mode, seed, sig_fld, svc_fld, len_fld and pl_data outside an accepting slot have no effect on the frame in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one outgoing bit slot per pulse |
| start | input | 1 | Frame start request, taken in idle |
| short_mode | input | 1 | 1 selects the short preamble, 0 the long one |
| seed | input | 7 | Scrambler preset for long-preamble frames |
| sig_fld | input | 8 | Header signal field |
| svc_fld | input | 8 | Header service field |
| len_fld | input | 16 | Header length field, payload length in octets |
| pl_valid | input | 1 | Upstream payload bit is valid |
| pl_data | input | 1 | Upstream payload bit |
| tx_rdy | output | 1 | Payload bit requested in this slot |
| tx_bit | output | 1 | Scrambled serial output bit |
| tx_bit_vld | output | 1 | tx_bit carries a frame bit for the current slot |
| busy | output | 1 | Frame in progress |

## Verification
The hardest case to reach is a payload slot that the upstream source leaves empty, while the bit enable is sparse and a second start request arrives mid-frame. A missed stall or an unwanted restart only shows up as a drift in the self-synchronizing scrambler output many bits later. The vector table therefore runs frames with the enable at every first, second or third cycle. The source withholds every third offered payload bit, a start pulse is injected partway into each frame, and all captured inputs are inverted right after the start. The bench then compares the whole received stream with a model built from the requirements, and it descrambles the check-word bits on their own.

// File: rtl/dsss_framer_pkg.sv
package dsss_framer_pkg;

    localparam int SFD_W = 16;
    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SYNC = 3'd1,
        PH_SFD  = 3'd2,
        PH_HDR  = 3'd3,
        PH_PAY  = 3'd4
    } phase_e;

endpackage

// File: rtl/dsss_scrambler.sv
// Self-synchronizing division scrambler, output fed back into the register.
module dsss_scrambler #(
    parameter int W     = 7,
    parameter int TAP_A = 4,
    parameter int TAP_B = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    input  logic         din,
    output logic         dout
);

    logic [W-1:0] s_q, s_d;

    assign dout = din ^ s_q[TAP_A-1] ^ s_q[TAP_B-1];

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d = seed;
        end else if (step) begin
            s_d = {s_q[W-2:0], dout};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dsss_hdr_crc.sv
// Unrolled serial CRC over the header fields, bit 0 of the vector first.
module dsss_hdr_crc #(
    parameter int          DW   = 32,
    parameter int          CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc
);

    logic [CW-1:0] chain [DW+1];

    assign chain[0] = '1;

    for (genvar i = 0; i < DW; i++) begin : g_stage
        logic fb;
        assign fb          = data[i] ^ chain[i][CW-1];
        assign chain[i+1]  = {chain[i][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc = ~chain[DW];

endmodule

// File: rtl/dsss_bit_sel.sv
// Picks the unscrambled bit for the current phase and position.
module dsss_bit_sel
    import dsss_framer_pkg::*;
#(
    parameter int               HDR_W     = 48,
    parameter int               IW        = $clog2(HDR_W),
    parameter logic [SFD_W-1:0] SFD_LONG  = 16'hF3A0,
    parameter logic [SFD_W-1:0] SFD_SHORT = 16'h05CF
) (
    input  phase_e           ph,
    input  logic             short_m,
    input  logic [IW-1:0]    idx,
    input  logic [HDR_W-1:0] hdr,
    input  logic             pl_data,
    output logic             raw
);

    localparam int SFD_IW = $clog2(SFD_W);

    logic [SFD_W-1:0] sfd_w;

    assign sfd_w = short_m ? SFD_SHORT : SFD_LONG;

    always_comb begin
        unique case (ph)
            PH_SYNC: raw = ~short_m;
            PH_SFD:  raw = sfd_w[idx[SFD_IW-1:0]];
            PH_HDR:  raw = hdr[idx];
            PH_PAY:  raw = pl_data;
            default: raw = 1'b0;
        endcase
    end

endmodule

// File: rtl/dsss_tx_framer.sv
module dsss_tx_framer
    import dsss_framer_pkg::*;
#(
    parameter int                LONG_SYNC  = 128,
    parameter int                SHORT_SYNC = 56,
    parameter int                SEED_W     = 7,
    parameter int                FLD_W      = 8,
    parameter int                LEN_W      = 16,
    parameter logic [SEED_W-1:0] SHORT_SEED = 7'h1B,
    parameter logic [SFD_W-1:0]  SFD_LONG   = 16'hF3A0,
    parameter logic [SFD_W-1:0]  SFD_SHORT  = 16'h05CF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              start,
    input  logic              short_mode,
    input  logic [SEED_W-1:0] seed,
    input  logic [FLD_W-1:0]  sig_fld,
    input  logic [FLD_W-1:0]  svc_fld,
    input  logic [LEN_W-1:0]  len_fld,
    input  logic              pl_valid,
    input  logic              pl_data,
    output logic              tx_rdy,
    output logic              tx_bit,
    output logic              tx_bit_vld,
    output logic              busy
);

    localparam int DAT_W   = 2*FLD_W + LEN_W;
    localparam int HDR_W   = DAT_W + CRC_W;
    localparam int HDR_IW  = $clog2(HDR_W);
    localparam int SYNC_CW = $clog2(LONG_SYNC + 1);
    localparam int PAY_CW  = LEN_W + 3;
    localparam int CNT_W   = (PAY_CW > SYNC_CW) ? PAY_CW : SYNC_CW;

    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_SYNC - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_SYNC - 1);
    localparam logic [CNT_W-1:0] SFD_LAST   = CNT_W'(SFD_W - 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_W - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             short_m;
        logic [HDR_W-1:0] hdr;
        logic             tx_bit;
        logic             tx_vld;
    } frm_t;

    frm_t q, d;

    logic [CRC_W-1:0]  crc_w;
    logic [LEN_W-1:0]  len_q_w;
    logic [CNT_W-1:0]  sync_last_w;
    logic [CNT_W-1:0]  pay_last_w;
    logic              raw_w;
    logic              scr_w;
    logic              emit_w;
    logic              load_w;
    logic [SEED_W-1:0] seed_w;

    dsss_hdr_crc #(
        .DW   (DAT_W),
        .CW   (CRC_W),
        .POLY (CRC_POLY)
    ) u_crc (
        .data ({len_fld, svc_fld, sig_fld}),
        .crc  (crc_w)
    );

    dsss_bit_sel #(
        .HDR_W     (HDR_W),
        .IW        (HDR_IW),
        .SFD_LONG  (SFD_LONG),
        .SFD_SHORT (SFD_SHORT)
    ) u_sel (
        .ph      (q.ph),
        .short_m (q.short_m),
        .idx     (q.cnt[HDR_IW-1:0]),
        .hdr     (q.hdr),
        .pl_data (pl_data),
        .raw     (raw_w)
    );

    assign load_w = (q.ph == PH_IDLE) && start;
    assign seed_w = short_mode ? SHORT_SEED : seed;

    dsss_scrambler #(
        .W     (SEED_W),
        .TAP_A (4),
        .TAP_B (7)
    ) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .seed  (seed_w),
        .step  (emit_w),
        .din   (raw_w),
        .dout  (scr_w)
    );

    assign len_q_w     = q.hdr[2*FLD_W +: LEN_W];
    assign sync_last_w = q.short_m ? SHORT_LAST : LONG_LAST;
    assign pay_last_w  = CNT_W'({len_q_w, 3'b000}) - CNT_W'(1);

    // A bit leaves the block in this slot
    always_comb begin
        unique case (q.ph)
            PH_SYNC, PH_SFD, PH_HDR: emit_w = bit_en;
            PH_PAY:                  emit_w = bit_en & pl_valid;
            default:                 emit_w = 1'b0;
        endcase
    end

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph      = PH_SYNC;
                    d.cnt     = '0;
                    d.short_m = short_mode;
                    d.hdr     = {crc_w, len_fld, svc_fld, sig_fld};
                end
            end
            PH_SYNC: begin
                if (emit_w) begin
                    if (q.cnt == sync_last_w) begin
                        d.ph  = PH_SFD;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_SFD: begin
                if (emit_w) begin
                    if (q.cnt == SFD_LAST) begin
                        d.ph  = PH_HDR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_HDR: begin
                if (emit_w) begin
                    if (q.cnt == HDR_LAST) begin
                        d.ph  = (len_q_w == '0) ? PH_IDLE : PH_PAY;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_PAY: begin
                if (emit_w) begin
                    if (q.cnt == pay_last_w) begin
                        d.ph  = PH_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                d.ph  = PH_IDLE;
                d.cnt = '0;
            end
        endcase
        if (bit_en) begin
            d.tx_vld = emit_w;
            d.tx_bit = emit_w & scr_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_rdy     = (q.ph == PH_PAY) && bit_en;
    assign tx_bit     = q.tx_bit;
    assign tx_bit_vld = q.tx_vld;
    assign busy       = (q.ph != PH_IDLE);

endmodule

// File: rtl/dsss_tx_framer_chk.sv
module dsss_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic start,
    input logic pl_valid,
    input logic tx_rdy,
    input logic tx_bit,
    input logic tx_bit_vld,
    input logic busy
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_bit && !tx_bit_vld && !busy));

    // R1
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit_vld |-> !tx_bit);

    // R2
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R8
    rdy_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rdy |-> (busy && bit_en));

    // R9
    stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && !pl_valid) |=> !tx_bit_vld);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(tx_bit_vld)));

    // R11
    end_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_en) |=> busy);

endmodule

bind dsss_tx_framer dsss_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .start      (start),
    .pl_valid   (pl_valid),
    .tx_rdy     (tx_rdy),
    .tx_bit     (tx_bit),
    .tx_bit_vld (tx_bit_vld),
    .busy       (busy)
);

// File: tb/tb_dsss_tx_framer.sv
module tb_dsss_tx_framer;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, bit_en, start, short_mode, pl_valid, pl_data;
    logic [6:0]  seed;
    logic [7:0]  sig_fld, svc_fld;
    logic [15:0] len_fld;
    logic        tx_rdy, tx_bit, tx_bit_vld, busy;

    int errors = 0;
    int checks = 0;

    logic exp_raw  [256];
    logic exp_bits [256];
    logic got      [256];

    typedef struct packed {
        logic        sh;
        logic [6:0]  seed;
        logic [7:0]  sig;
        logic [7:0]  svc;
        logic [15:0] len;
        logic [31:0] pl;
        logic [1:0]  div;
        logic        stall;
        logic [8:0]  nbits;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 7'h5D, 8'h0A, 8'h00, 16'd2, 32'h0000_C3A5, 2'd1, 1'b0, 9'd208},
        '{1'b1, 7'h00, 8'h14, 8'h04, 16'd3, 32'h0012_3456, 2'd2, 1'b1, 9'd144},
        '{1'b0, 7'h7F, 8'h6E, 8'h80, 16'd0, 32'h0000_0000, 2'd3, 1'b0, 9'd192},
        '{1'b1, 7'h11, 8'h37, 8'h00, 16'd4, 32'hDEAD_BEEF, 2'd1, 1'b1, 9'd152},
        '{1'b0, 7'h00, 8'h0A, 8'h00, 16'd1, 32'h0000_00FF, 2'd1, 1'b1, 9'd200},
        '{1'b0, 7'h01, 8'hFF, 8'hFF, 16'd4, 32'h8000_0001, 2'd2, 1'b0, 9'd224}
    };

    dsss_tx_framer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .start      (start),
        .short_mode (short_mode),
        .seed       (seed),
        .sig_fld    (sig_fld),
        .svc_fld    (svc_fld),
        .len_fld    (len_fld),
        .pl_valid   (pl_valid),
        .pl_data    (pl_data),
        .tx_rdy     (tx_rdy),
        .tx_bit     (tx_bit),
        .tx_bit_vld (tx_bit_vld),
        .busy       (busy)
    );

    task automatic chk(input string what, input logic ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // Expected stream built from the requirement text
    task automatic build_exp(input vec_t v, output int n);
        int k, sl;
        logic [15:0] c, sfd;
        logic [31:0] hw;
        logic [47:0] h;
        logic [6:0]  sd;
        logic        fb;
        logic        ext [264];
        k  = 0;
        sl = v.sh ? 56 : 128;
        for (int i = 0; i < sl; i++) begin
            exp_raw[k] = !v.sh;
            k++;
        end
        sfd = v.sh ? 16'h05CF : 16'hF3A0;
        for (int i = 0; i < 16; i++) begin
            exp_raw[k] = sfd[i];
            k++;
        end
        hw = {v.len, v.svc, v.sig};
        c  = 16'hFFFF;
        for (int i = 0; i < 32; i++) begin
            fb = hw[i] ^ c[15];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        c = ~c;
        h = {c, hw};
        for (int i = 0; i < 48; i++) begin
            exp_raw[k] = h[i];
            k++;
        end
        for (int i = 0; i < int'(v.len) * 8; i++) begin
            exp_raw[k] = v.pl[i];
            k++;
        end
        n  = k;
        sd = v.sh ? 7'h1B : v.seed;
        for (int i = 0; i < 7; i++) ext[6-i] = sd[i];
        for (int j = 0; j < n; j++) begin
            ext[j+7]    = exp_raw[j] ^ ext[j+3] ^ ext[j];
            exp_bits[j] = ext[j+7];
        end
    endtask

    task automatic run_vec(input vec_t v, input int vi);
        int n_exp, ng, steps, offer, pidx, sl, lim;
        int hold_err, stall_err, pre_err, hdr_err, crc_err, pay_err, all_err;
        logic en, rdy, pb, pv, dr;
        string pre_tag, end_tag;
        build_exp(v, n_exp);
        sl      = v.sh ? 56 : 128;
        pre_tag = v.sh ? "R4" : "R3";
        end_tag = (v.len == 16'd0) ? "R11" : "R8";

        @(negedge clk);
        short_mode = v.sh;
        seed       = v.seed;
        sig_fld    = v.sig;
        svc_fld    = v.svc;
        len_fld    = v.len;
        start      = 1'b1;
        bit_en     = 1'b0;
        pl_valid   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk($sformatf("R2 vec%0d busy after start", vi), busy === 1'b1, int'(busy), 1);
        // R12: captured values must not follow the inputs any more
        short_mode = ~v.sh;
        seed       = ~v.seed;
        sig_fld    = ~v.sig;
        svc_fld    = ~v.svc;
        len_fld    = ~v.len;

        ng = 0; steps = 0; offer = 0; pidx = 0; hold_err = 0; stall_err = 0;
        while (busy && steps < 4000) begin
            en     = (steps % int'(v.div)) == 0;
            bit_en = en;
            start  = (steps == 10);
            #1;
            rdy = tx_rdy;
            if (rdy) begin
                offer++;
                if (v.stall && (offer % 3 == 0)) begin
                    pl_valid = 1'b0;
                end else begin
                    pl_valid = 1'b1;
                    pl_data  = v.pl[pidx];
                end
            end else begin
                pl_valid = 1'b0;
                pl_data  = ~pl_data;
            end
            pb = tx_bit;
            pv = tx_bit_vld;
            @(posedge clk);
            @(negedge clk);
            if (rdy && pl_valid) pidx++;
            if (en) begin
                if (tx_bit_vld) begin
                    if (ng < 256) got[ng] = tx_bit;
                    ng++;
                end
                if (rdy && !pl_valid && tx_bit_vld) stall_err++;
            end else if (tx_bit !== pb || tx_bit_vld !== pv) begin
                hold_err++;
            end
            steps++;
        end
        bit_en   = 1'b0;
        pl_valid = 1'b0;
        start    = 1'b0;

        pre_err = 0; hdr_err = 0; crc_err = 0; pay_err = 0; all_err = 0;
        lim = (ng < n_exp) ? ng : n_exp;
        if (lim > 256) lim = 256;
        for (int k = 0; k < lim; k++) begin
            if (got[k] !== exp_bits[k]) begin
                all_err++;
                if (k < sl + 16) pre_err++;
                else if (k < sl + 64) hdr_err++;
                else pay_err++;
            end
        end
        for (int k = sl + 48; k < sl + 64 && k < lim; k++) begin
            dr = got[k] ^ got[k-4] ^ got[k-7];
            if (dr !== exp_raw[k]) crc_err++;
        end

        chk($sformatf("%s vec%0d bit count", pre_tag, vi), ng == int'(v.nbits), ng, int'(v.nbits));
        chk($sformatf("%s vec%0d sync+delimiter mismatches", pre_tag, vi), pre_err == 0, pre_err, 0);
        chk($sformatf("R5 vec%0d header mismatches", vi), hdr_err == 0, hdr_err, 0);
        chk($sformatf("R6 vec%0d descrambled check word mismatches", vi), crc_err == 0, crc_err, 0);
        chk($sformatf("R8 vec%0d payload mismatches", vi), pay_err == 0, pay_err, 0);
        chk($sformatf("R2 R7 R12 vec%0d full stream mismatches", vi), all_err == 0, all_err, 0);
        chk($sformatf("%s vec%0d idle at end", end_tag, vi), busy === 1'b0, int'(busy), 0);
        chk($sformatf("R10 vec%0d output changed without enable", vi), hold_err == 0, hold_err, 0);
        chk($sformatf("R9 vec%0d stalled slot emitted a bit", vi), stall_err == 0, stall_err, 0);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bit_en = 1'b1; start = 1'b0; short_mode = 1'b0;
        pl_valid = 1'b1; pl_data = 1'b1; seed = 7'h00;
        sig_fld = 8'h00; svc_fld = 8'h00; len_fld = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset tx_bit", tx_bit === 1'b0, int'(tx_bit), 0);
        chk("R1 reset tx_bit_vld", tx_bit_vld === 1'b0, int'(tx_bit_vld), 0);
        chk("R1 reset busy", busy === 1'b0, int'(busy), 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 R8: idle with enable and valid data does not request or emit
        chk("R1 idle tx_rdy", tx_rdy === 1'b0, int'(tx_rdy), 0);
        chk("R1 idle tx_bit_vld", tx_bit_vld === 1'b0, int'(tx_bit_vld), 0);
        bit_en = 1'b0; pl_valid = 1'b0;

        for (int i = 0; i < 6; i++) run_vec(VECS[i], i);

        // R1: reset in the middle of a frame
        @(negedge clk);
        short_mode = 1'b0; seed = 7'h2A; sig_fld = 8'h0A; len_fld = 16'd2; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; bit_en = 1'b1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R1 busy before mid-frame reset", busy === 1'b1, int'(busy), 1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid-frame reset busy", busy === 1'b0, int'(busy), 0);
        chk("R1 mid-frame reset tx_bit_vld", tx_bit_vld === 1'b0, int'(tx_bit_vld), 0);
        chk("R1 mid-frame reset tx_bit", tx_bit === 1'b0, int'(tx_bit), 0);
        rst_n = 1'b1; bit_en = 1'b0;
        @(negedge clk);
        run_vec(VECS[0], 6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule